// File: doc/BRIEF.md
# Serial Key Unlock Recognizer

This block sits beside a byte-wide SRAM port and watches its completed bus cycles for a 64-bit unlock key. The key arrives one bit per write cycle on data line 0; the address and the other data lines play no part. A read cycle arms a fresh attempt by putting the compare pointer at key bit 0. Every write whose bit agrees with the key bit under the pointer moves the pointer on. The first disagreeing bit locks the attempt, so all further writes are ignored until another read arms it again.

When the 64th bit agrees, the block raises an unlock flag. That flag tells the surrounding logic to route the next cycles to a timekeeping transfer engine instead of the memory. Until the flag rises, the block changes nothing about memory accesses. The flag stays up until the transfer engine reports that it has finished or asks to abort. Either report returns the recognizer to idle, and a read is then needed before a new attempt starts.

Top module: `unlock_key_recognizer`

## Requirements
- R1: Key bit i (i = 0 to 63) is bit i of 64'h5CA3_3AC5_5CA3_3AC5, which is the byte stream C5, 3A, A3, 5C, C5, 3A, A3, 5C with each byte sent least significant bit first. Only `wr_bit` (data line 0) is compared.
- R2: After a synchronous active-low reset, `unlocked` is 0 and the recognizer is idle. In the idle state, writes are ignored until a read arrives.
- R3: While the block is not unlocked, a read strobe resets the pointer to key bit 0 and arms the attempt. This happens from any progress point and from the locked state. A read and a write in the same cycle count as a read.
- R4: In an armed attempt, a write whose bit equals the key bit at the pointer advances the pointer by one.
- R5: In an armed attempt, a write whose bit differs from the key bit locks the attempt with the pointer unchanged. Every later write, including correct ones, is then ignored until a read.
- R6: The write that matches key bit 63 makes `unlocked` read 1 on the clock edge that samples that write. A key sent with any wrong bit never sets `unlocked`.
- R7: While `unlocked` is 1, read and write strobes have no effect, and the flag stays high until a done or abort report.
- R8: `xfer_done` while unlocked clears `unlocked` at the next edge and returns the block to idle. A full key sent afterwards without a read does not unlock.
- R9: `xfer_abort` while unlocked clears `unlocked` at the next edge and returns the block to idle, in the same way as R8.
- R10: `xfer_done` and `xfer_abort` have no effect while the block is not unlocked. In particular, they do not disturb an attempt in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_strobe | input | 1 | One-cycle pulse per completed read cycle |
| wr_strobe | input | 1 | One-cycle pulse per completed write cycle |
| wr_bit | input | 1 | Data line 0 value of the write marked by wr_strobe |
| xfer_done | input | 1 | Transfer engine finished its cycles |
| xfer_abort | input | 1 | Transfer engine aborted |
| unlocked | output | 1 | Key matched; cycles belong to the transfer engine |

## Verification
Every result of this block lands one clock edge after its stimulus. A strobe or report presented in one cycle shows up in `unlocked` at the next rising edge; there is no extra pipeline stage. The bench drives each cycle's inputs on the falling edge and samples `unlocked` just after the following rising edge. It compares that sample against a bench model stepped with the same inputs. Pointer and lock behaviour that cannot be seen at the port directly is made visible by sending the rest of the key and observing whether the flag rises.

// File: rtl/ukr_pkg.sv
// Shared types and constants for the unlock key recognizer.
package ukr_pkg;
    // Recognizer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2,
        ST_OPEN   = 2'd3
    } ukr_state_e;

    // Bus event seen in one cycle after arbitration.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_READ  = 2'd1,
        EV_WRITE = 2'd2
    } ukr_event_e;

    // Default key: bytes C5,3A,A3,5C,C5,3A,A3,5C, each LSB first; bit i is sent i-th.
    localparam logic [63:0] UKR_DEFAULT_KEY = 64'h5CA3_3AC5_5CA3_3AC5;
endpackage

// File: rtl/ukr_event_decode.sv
// Classifies one cycle's strobes into a single bus event.
// Assumes strobes are one-cycle pulses; read takes priority over write.
module ukr_event_decode
    import ukr_pkg::*;
(
    input  logic       rd_strobe,
    input  logic       wr_strobe,
    output ukr_event_e event_o
);
    // Pick the event, read winning a collision.
    always_comb begin
        if (rd_strobe)      event_o = EV_READ;
        else if (wr_strobe) event_o = EV_WRITE;
        else                event_o = EV_NONE;
    end
endmodule

// File: rtl/ukr_key_select.sv
// Returns the key bit addressed by the compare pointer.
// Assumes KEY_BITS is a power of two so the pointer covers it exactly.
module ukr_key_select #(
    parameter int          KEY_BITS = 64,
    parameter logic [63:0] KEY      = ukr_pkg::UKR_DEFAULT_KEY,
    localparam int         PTR_W    = $clog2(KEY_BITS)
) (
    input  logic [PTR_W-1:0] ptr,
    output logic             key_bit
);
    // Index the key constant by the pointer.
    always_comb key_bit = KEY[ptr];
endmodule

// File: rtl/ukr_sequencer.sv
// Pointer and state machine of the recognizer.
// Assumes one event per cycle and that the key bit matches the current pointer.
module ukr_sequencer
    import ukr_pkg::*;
#(
    parameter int  KEY_BITS = 64,
    localparam int PTR_W    = $clog2(KEY_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ukr_event_e       event_i,
    input  logic             wr_bit,
    input  logic             key_bit,
    input  logic             xfer_done,
    input  logic             xfer_abort,
    output ukr_state_e       state_q,
    output logic [PTR_W-1:0] ptr_q
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_BITS - 1);

    ukr_state_e       state_d;
    logic [PTR_W-1:0] ptr_d;

    // Next-state and next-pointer logic.
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (state_q == ST_OPEN) begin
            if (xfer_done || xfer_abort) begin
                state_d = ST_IDLE;
                ptr_d   = '0;
            end
        end else if (event_i == EV_READ) begin
            state_d = ST_ARMED;
            ptr_d   = '0;
        end else if (event_i == EV_WRITE && state_q == ST_ARMED) begin
            if (wr_bit != key_bit) begin
                state_d = ST_LOCKED;
            end else if (ptr_q == LAST) begin
                state_d = ST_OPEN;
                ptr_d   = '0;
            end else begin
                ptr_d = ptr_q + 1'b1;
            end
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end
endmodule

// File: rtl/unlock_key_recognizer.sv
// Top of the serial unlock key recognizer: watches completed bus cycles
// and raises 'unlocked' once the full key has been written on data line 0.
// Assumes strobes are synchronous single-cycle pulses.
module unlock_key_recognizer
    import ukr_pkg::*;
#(
    parameter int          KEY_BITS = 64,
    parameter logic [63:0] KEY      = UKR_DEFAULT_KEY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic wr_strobe,
    input  logic wr_bit,
    input  logic xfer_done,
    input  logic xfer_abort,
    output logic unlocked
);
    localparam int PTR_W = $clog2(KEY_BITS);

    ukr_event_e       bus_event;
    ukr_state_e       state_q;
    logic [PTR_W-1:0] ptr_q;
    logic             key_bit;

    ukr_event_decode i_decode (
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .event_o   (bus_event)
    );

    ukr_key_select #(.KEY_BITS(KEY_BITS), .KEY(KEY)) i_key (
        .ptr     (ptr_q),
        .key_bit (key_bit)
    );

    ukr_sequencer #(.KEY_BITS(KEY_BITS)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (bus_event),
        .wr_bit     (wr_bit),
        .key_bit    (key_bit),
        .xfer_done  (xfer_done),
        .xfer_abort (xfer_abort),
        .state_q    (state_q),
        .ptr_q      (ptr_q)
    );

    // Flag follows the open state.
    always_comb unlocked = (state_q == ST_OPEN);
endmodule

// File: rtl/ukr_checker.sv
// Temporal checks on the recognizer, bound to its top module.
module ukr_checker
    import ukr_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_strobe,
    input logic             wr_strobe,
    input logic             xfer_done,
    input logic             xfer_abort,
    input logic             unlocked,
    input ukr_state_e       state_q,
    input logic [PTR_W-1:0] ptr_q
);
    localparam logic [PTR_W-1:0] LAST = '1;

    a_r2_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!unlocked && state_q == ST_IDLE));

    a_r3_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state_q != ST_OPEN) |=> (state_q == ST_ARMED && ptr_q == '0));

    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && wr_strobe && !rd_strobe && ptr_q != LAST)
        |=> (state_q == ST_LOCKED || ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

    a_r5_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !rd_strobe) |=> (state_q == ST_LOCKED && $stable(ptr_q)));

    a_r6_open_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_strobe && !rd_strobe));

    a_r7_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !xfer_done && !xfer_abort) |=> unlocked);

    a_r8_close_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && (xfer_done || xfer_abort)) |=> (!unlocked && state_q == ST_IDLE));
endmodule

bind unlock_key_recognizer ukr_checker #(.PTR_W(PTR_W)) i_ukr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .xfer_done  (xfer_done),
    .xfer_abort (xfer_abort),
    .unlocked   (unlocked),
    .state_q    (state_q),
    .ptr_q      (ptr_q)
);

// File: tb/test_unlock_key_recognizer.sv
module test_unlock_key_recognizer;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] KEY        = 64'h5CA3_3AC5_5CA3_3AC5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_strobe = 1'b0, wr_strobe = 1'b0, wr_bit = 1'b0;
    logic xfer_done = 1'b0, xfer_abort = 1'b0;
    logic unlocked;

    int checks = 0;
    int failures = 0;

    // Bench model: 0 idle, 1 armed, 2 locked, 3 open
    int m_st  = 0;
    int m_ptr = 0;

    unlock_key_recognizer i_unlock_key_recognizer (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .wr_bit(wr_bit), .xfer_done(xfer_done), .xfer_abort(xfer_abort),
        .unlocked(unlocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic key_at(input int i);
        return KEY[i];
    endfunction

    task automatic model_step(input logic rd, input logic wr, input logic b,
                              input logic dn, input logic ab);
        if (m_st == 3) begin
            if (dn || ab) begin m_st = 0; m_ptr = 0; end
        end else if (rd) begin
            m_st = 1; m_ptr = 0;
        end else if (wr && m_st == 1) begin
            if (b != key_at(m_ptr)) m_st = 2;
            else if (m_ptr == 63) begin m_st = 3; m_ptr = 0; end
            else m_ptr = m_ptr + 1;
        end
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (unlocked !== exp) begin
            failures++;
            $display("FAIL %s: unlocked actual=%b expected=%b at %0t", req, unlocked, exp, $time);
        end
    endtask

    // One bus cycle: drive on negedge, check just after the next posedge.
    task automatic cyc(input logic rd, input logic wr, input logic b,
                       input logic dn, input logic ab, input string req);
        @(negedge clk);
        rd_strobe = rd; wr_strobe = wr; wr_bit = b; xfer_done = dn; xfer_abort = ab;
        model_step(rd, wr, b, dn, ab);
        @(posedge clk);
        #1;
        check(req, (m_st == 3));
        @(negedge clk);
        rd_strobe = 0; wr_strobe = 0; xfer_done = 0; xfer_abort = 0;
    endtask

    // Send key bits [from..to]; optionally flip one bit index.
    task automatic send_key(input int from, input int to, input int flip, input string req);
        for (int i = from; i <= to; i++)
            cyc(0, 1, key_at(i) ^ (i == flip), 0, 0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B_3C4D));
        repeat (3) @(posedge clk);
        #1; check("R2", 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R2: idle ignores a full key without a prior read
        send_key(0, 63, -1, "R2");
        check("R2", 1'b0);

        // R1/R4/R6: read then the exact key unlocks
        cyc(1, 0, 0, 0, 0, "R3");
        send_key(0, 63, -1, "R6");
        check("R6", 1'b1);

        // R7: strobes ignored while open
        cyc(1, 0, 0, 0, 0, "R7");
        cyc(0, 1, 1, 0, 0, "R7");
        cyc(1, 1, 0, 0, 0, "R7");

        // R8: done closes; then full key without read does not unlock
        cyc(0, 0, 0, 1, 0, "R8");
        send_key(0, 63, -1, "R8");
        check("R8", 1'b0);

        // R1: upper data lines irrelevant is implicit; wrong final bit never unlocks
        cyc(1, 0, 0, 0, 0, "R3");
        send_key(0, 63, 63, "R6");
        // R5: mismatch at bit 10 then correct remainder stays locked
        cyc(1, 0, 0, 0, 0, "R3");
        send_key(0, 63, 10, "R5");
        send_key(10, 63, -1, "R5");
        check("R5", 1'b0);

        // R3: read mid-attempt restarts from bit 0
        cyc(1, 0, 0, 0, 0, "R3");
        send_key(0, 30, -1, "R3");
        cyc(1, 1, key_at(31), 0, 0, "R3");
        send_key(31, 63, -1, "R3");
        cyc(1, 0, 0, 0, 0, "R3");
        send_key(0, 63, -1, "R3");
        check("R3", 1'b1);

        // R9: abort closes
        cyc(0, 0, 0, 0, 1, "R9");
        check("R9", 1'b0);

        // R10: done/abort during an attempt do nothing
        cyc(1, 0, 0, 0, 0, "R10");
        send_key(0, 20, -1, "R10");
        cyc(0, 0, 0, 1, 1, "R10");
        send_key(21, 63, -1, "R10");
        check("R10", 1'b1);
        cyc(0, 0, 0, 1, 0, "R8");

        // Random mix, biased toward correct key bits
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            logic good = (m_st == 1) ? key_at(m_ptr) : 1'($urandom_range(0, 1));
            if (r < 3)       cyc(1, 0, 0, 0, 0, "R3");
            else if (r < 5)  cyc(0, 1, ~good, 0, 0, "R5");
            else if (r < 7)  cyc(0, 0, 0, 1, 0, "R8");
            else if (r < 9)  cyc(0, 0, 0, 0, 1, "R9");
            else if (r < 12) cyc(0, 0, 0, 0, 0, "R7");
            else             cyc(0, 1, good, 0, 0, "R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule